// File: doc/BRIEF.md
# Read Turnaround Gap Inserter

This block sits beside the access sequencer of an external chip-select bus controller. Once a read on one of eight chip selects finishes, it adds a programmable number of idle cycles before any new access may begin. This gives the selected peripheral time to float its data pins before another device drives the shared bus. Each chip select has its own count, from 0 to 3. The counts live in one 32-bit configuration word that can be written and read back.

The sequencer reports the last cycle of every access with a one-cycle end strobe. With the strobe it gives the direction of the access (read or write) and the chip select number. On a read end, the block latches the count that belongs to that chip select and starts counting down. While the count is non-zero, the block forces the bus-busy output high and withholds the grant for a new access. The gap cycles follow every cycle that the access already took, with no overlap. The gap applies the same way to single and burst reads. A write end adds nothing.

Top module: `rdgap_ctrl`

## Requirements
- R1: During reset and right after it, `cfg_rdata` reads 0x33333333, so every count is 3. No gap is active, `start_gnt` follows `start_req`, and `busy_out` follows `busy_in`.
- R2: The count for chip select n sits in `cfg_rdata[4n+1:4n]`, with bit 4n+1 as the more significant bit. Every other bit of the configuration word reads as zero whatever was written to it.
- R3: If `acc_done` is high with `acc_read`=1 in cycle t and the chip select's count is N, the gap covers exactly cycles t+1 to t+N.
- R4: With a count of 0, a read end adds no gap, and `start_gnt` can be high in cycle t+1.
- R5: An access end with `acc_read`=0 starts no gap.
- R6: While a gap is active, `start_gnt` stays low whatever `start_req` does. Otherwise `start_gnt` equals `start_req`.
- R7: `busy_out` is high whenever `busy_in` is high or a gap is active, and low otherwise.
- R8: The gap length is fixed by the count at the read-end cycle. A configuration write in that cycle or during the gap leaves the running gap unchanged.
- R9: The gap length comes from the field of the chip select given on `acc_cs` with the end strobe. Fields of other chip selects play no part.
- R10: A write with `cfg_we`=1 shows in `cfg_rdata` from the next cycle. Without `cfg_we` the configuration does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_wdata | input | 32 | Configuration word write data |
| cfg_rdata | output | 32 | Configuration word read-back |
| acc_done | input | 1 | Last cycle of the current bus access |
| acc_read | input | 1 | Direction of the ending access, 1 = read |
| acc_cs | input | 3 | Chip select of the ending access |
| start_req | input | 1 | Sequencer asks to begin a new access |
| start_gnt | output | 1 | New access may begin this cycle |
| busy_in | input | 1 | Bus-busy from the access sequencer |
| busy_out | output | 1 | Bus-busy extended over the turnaround gap |

## Verification
The assertions assume that the sequencer raises `acc_done` only after `start_gnt` has let an access through, so an end strobe never arrives while a gap is still counting. A reload inside a gap is therefore treated as outside legal use. The stimulus drives end strobes only when the bench's reference model shows the gap as idle. Configuration writes, `busy_in` and `start_req` are free in every cycle, including inside a gap.

// File: rtl/rdgap_pkg.sv
`timescale 1ns/1ps
package rdgap_pkg;
  localparam int unsigned NUM_CS_DEF = 8;
  localparam int unsigned CNT_W_DEF  = 2;
  localparam int unsigned STRIDE_DEF = 4;
  localparam int unsigned REG_W_DEF  = 32;
endpackage

// File: rtl/rdgap_rst_sync.sv
`timescale 1ns/1ps
module rdgap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rdgap_cfg.sv
`timescale 1ns/1ps
module rdgap_cfg #(
  parameter int unsigned NUM_CS = rdgap_pkg::NUM_CS_DEF,
  parameter int unsigned CNT_W  = rdgap_pkg::CNT_W_DEF,
  parameter int unsigned STRIDE = rdgap_pkg::STRIDE_DEF,
  parameter int unsigned REG_W  = rdgap_pkg::REG_W_DEF,
  localparam int unsigned FLAT_W = NUM_CS * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [FLAT_W-1:0] fields_o
);
  logic [FLAT_W-1:0] field_q;
  logic [FLAT_W-1:0] field_d;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_field
    always_comb begin
      field_d[g*CNT_W +: CNT_W] = we_i ? wdata_i[g*STRIDE +: CNT_W]
                                       : field_q[g*CNT_W +: CNT_W];
    end
  end

  // Field flops: reset to all ones, the longest turnaround.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) field_q <= '1;
    else        field_q <= field_d;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      rdata_o[i*STRIDE +: CNT_W] = field_q[i*CNT_W +: CNT_W];
    end
  end

  assign fields_o = field_q;

  function automatic logic [REG_W-1:0] used_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CS; i++) m[i*STRIDE +: CNT_W] = '1;
    return m;
  endfunction
  localparam logic [REG_W-1:0] USED = used_mask();

  // R2: reserved positions read back as zero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & ~USED) == '0);
  // R10: configuration holds without a write
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(fields_o));
  // R10: a write appears at the read-back one cycle later
  p_cfg_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ((rdata_o & USED) == ($past(wdata_i) & USED)));
endmodule

// File: rtl/rdgap_sel.sv
`timescale 1ns/1ps
module rdgap_sel #(
  parameter int unsigned NUM_CS = rdgap_pkg::NUM_CS_DEF,
  parameter int unsigned CNT_W  = rdgap_pkg::CNT_W_DEF,
  localparam int unsigned CS_W  = $clog2(NUM_CS),
  localparam int unsigned FLAT_W = NUM_CS * CNT_W
) (
  input  logic [FLAT_W-1:0] fields_i,
  input  logic [CS_W-1:0]   cs_i,
  output logic [CNT_W-1:0]  cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (cs_i == CS_W'(i)) cnt_o = fields_i[i*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/rdgap_timer.sv
`timescale 1ns/1ps
module rdgap_timer #(
  parameter int unsigned CNT_W = rdgap_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             gap_o
);
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;
  logic             rem_en;

  always_comb begin
    rem_en = load_i || (rem_q != '0);
    rem_d  = rem_q;
    if (load_i)              rem_d = load_val_i;
    else if (rem_q != '0)    rem_d = rem_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign gap_o = (rem_q != '0);

  // R3: a read end loads the sampled count
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (rem_q == $past(load_val_i)));
  // R3: the gap shortens by one each cycle
  p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && gap_o) |=> (rem_q == $past(rem_q) - CNT_W'(1)));
  // R5: no reload keeps an idle timer idle
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !gap_o) |=> !gap_o);
endmodule

// File: rtl/rdgap_ctrl.sv
`timescale 1ns/1ps
module rdgap_ctrl #(
  parameter int unsigned NUM_CS = rdgap_pkg::NUM_CS_DEF,
  parameter int unsigned CNT_W  = rdgap_pkg::CNT_W_DEF,
  parameter int unsigned STRIDE = rdgap_pkg::STRIDE_DEF,
  parameter int unsigned REG_W  = rdgap_pkg::REG_W_DEF,
  localparam int unsigned CS_W  = $clog2(NUM_CS),
  localparam int unsigned FLAT_W = NUM_CS * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             acc_done,
  input  logic             acc_read,
  input  logic [CS_W-1:0]  acc_cs,
  input  logic             start_req,
  output logic             start_gnt,
  input  logic             busy_in,
  output logic             busy_out
);
  logic              rst_s_n;
  logic [FLAT_W-1:0] fields;
  logic [CNT_W-1:0]  sel_cnt;
  logic              rd_end;
  logic              gap;

  rdgap_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  rdgap_cfg #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .STRIDE(STRIDE), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_s_n), .we_i(cfg_we), .wdata_i(cfg_wdata),
    .rdata_o(cfg_rdata), .fields_o(fields)
  );

  rdgap_sel #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_sel (
    .fields_i(fields), .cs_i(acc_cs), .cnt_o(sel_cnt)
  );

  assign rd_end = acc_done && acc_read;

  rdgap_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_s_n), .load_i(rd_end), .load_val_i(sel_cnt), .gap_o(gap)
  );

  always_comb begin
    start_gnt = start_req && !gap;
    busy_out  = busy_in || gap;
  end

  // R6: no grant while the gap runs
  p_gnt_block_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    gap |-> !start_gnt);
  // R7: upstream busy always passes through
  p_busy_pass_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy_in |-> busy_out);
  // R4: zero count leaves the next cycle open
  p_zero_gap_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_end && sel_cnt == '0) |=> !gap);
  // R3: a non-zero count opens a gap next cycle
  p_open_gap_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_end && sel_cnt != '0) |=> (gap && busy_out && !start_gnt));
  // R5: a write end starts nothing
  p_write_nogap_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_done && !acc_read && !gap) |=> !gap);
endmodule

// File: tb/rdgap_ctrl_bench.sv
`timescale 1ns/1ps
module rdgap_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        acc_done;
  logic        acc_read;
  logic [2:0]  acc_cs;
  logic        start_req;
  logic        start_gnt;
  logic        busy_in;
  logic        busy_out;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  int cfg_m[8];
  int ref_cnt;

  rdgap_ctrl u_rdgap_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .acc_done(acc_done), .acc_read(acc_read),
    .acc_cs(acc_cs), .start_req(start_req), .start_gnt(start_gnt),
    .busy_in(busy_in), .busy_out(busy_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] pack_cfg();
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 8; i++) v[i*4 +: 2] = 2'(cfg_m[i]);
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive, compare with the model, clock, update the model.
  task automatic cyc(input string tag, input logic we, input logic [31:0] wd,
                     input logic done, input logic rd, input logic [2:0] cs,
                     input logic req, input logic bin);
    int old_cfg[8];
    cfg_we = we; cfg_wdata = wd; acc_done = done; acc_read = rd;
    acc_cs = cs; start_req = req; busy_in = bin;
    #1;
    chk(tag, "cfg_rdata", cfg_rdata, pack_cfg());
    chk(tag, "start_gnt", 32'(start_gnt), 32'(req && ref_cnt == 0));
    chk(tag, "busy_out", 32'(busy_out), 32'(bin || ref_cnt != 0));
    @(posedge clk);
    for (int i = 0; i < 8; i++) old_cfg[i] = cfg_m[i];
    if (done && rd)        ref_cnt = old_cfg[cs];
    else if (ref_cnt > 0)  ref_cnt = ref_cnt - 1;
    if (we) for (int i = 0; i < 8; i++) cfg_m[i] = int'(wd[i*4 +: 2]);
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input int n, input logic req);
    for (int k = 0; k < n; k++) cyc(tag, 1'b0, 32'h0, 1'b0, 1'b0, 3'd0, req, 1'b0);
  endtask

  function automatic logic [31:0] build(input int c0, input int c1, input int c2,
      input int c3, input int c4, input int c5, input int c6, input int c7);
    logic [31:0] v;
    v = '0;
    v[1:0] = 2'(c0); v[5:4] = 2'(c1); v[9:8] = 2'(c2); v[13:12] = 2'(c3);
    v[17:16] = 2'(c4); v[21:20] = 2'(c5); v[25:24] = 2'(c6); v[29:28] = 2'(c7);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) cfg_m[i] = 3;
    ref_cnt = 0;
    rst_n = 1'b0;
    cfg_we = 0; cfg_wdata = 0; acc_done = 0; acc_read = 0; acc_cs = 0;
    start_req = 0; busy_in = 0;
    @(negedge clk);
    // R1: reset state, with start_req passing straight through
    cyc("R1", 1'b0, 32'h0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0);
    cyc("R1", 1'b0, 32'h0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1);
    rst_n = 1'b1;
    idle("R1", 3, 1'b1);

    // R9/R3: default count 3 on chip select 5
    cyc("R3", 1'b0, 32'h0, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1);
    idle("R3", 5, 1'b1);

    // R2: reserved bits are dropped
    cyc("R2", 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
    idle("R2", 1, 1'b0);
    cyc("R2", 1'b1, 32'hCCCC_CCCC, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
    idle("R10", 1, 1'b0);

    // R9: distinct counts per chip select
    cyc("R10", 1'b1, build(0, 1, 2, 3, 3, 2, 1, 0), 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
    for (int c = 0; c < 8; c++) begin
      cyc("R9", 1'b0, 32'h0, 1'b1, 1'b1, 3'(c), 1'b1, 1'b0);
      idle("R9", 4, 1'b1);
    end

    // R4: zero count, next cycle is granted
    cyc("R4", 1'b0, 32'h0, 1'b1, 1'b1, 3'd0, 1'b1, 1'b0);
    cyc("R4", 1'b0, 32'h0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0);

    // R5: write ends on a chip select with count 3 add nothing
    cyc("R5", 1'b0, 32'h0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0);
    cyc("R5", 1'b0, 32'h0, 1'b1, 1'b0, 3'd4, 1'b1, 1'b0);
    idle("R5", 2, 1'b1);

    // R8: rewrite the config during a gap; the running gap keeps its length
    cyc("R8", 1'b0, 32'h0, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0);
    cyc("R8", 1'b1, 32'h0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0);
    idle("R8", 4, 1'b1);
    // R8: write in the same cycle as the read end
    cyc("R8", 1'b1, 32'h3333_3333, 1'b1, 1'b1, 3'd6, 1'b1, 1'b0);
    idle("R8", 3, 1'b1);

    // R6/R7: busy_in and start_req toggling through a gap
    cyc("R6", 1'b0, 32'h0, 1'b1, 1'b1, 3'd2, 1'b0, 1'b1);
    cyc("R7", 1'b0, 32'h0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0);
    cyc("R7", 1'b0, 32'h0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1);
    cyc("R6", 1'b0, 32'h0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0);
    cyc("R7", 1'b0, 32'h0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);

    // Mixed traffic; read/write ends only when the model shows no gap
    for (int k = 0; k < 3000; k++) begin
      logic dn;
      dn = ($urandom_range(0, 2) == 0) && (ref_cnt == 0);
      cyc("R3", ($urandom_range(0, 15) == 0), $urandom(), dn,
          1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule